// File: doc/BRIEF.md
# PHY Control-Port Register Target

This block is the responder side of a four-phase control port of the kind used to reach a PHY's internal configuration registers. A master presents a 16-bit word on `din` and raises one of four strobes. The four strobes are: capture an address, capture a data word, read, and write. The target carries out the requested action, raises `ack` after a programmable number of cycles and holds it until the strobe is dropped. Each step of a register access is a separate handshake: the address, the data word and the commit. A read places the addressed register on `dout` before acknowledging.

Inside, the block keeps a captured address, a holding data word and a small array of 16-bit registers indexed by the low address bits. Addresses past the end of the array read as zero and cannot be written. The acknowledge delay comes from an input, so a master's timeout handling can be exercised by setting a long delay. The block can therefore serve both as a behavioural stand-in for the PHY and as a checking partner for a sequencer.

Top module: `phy_ctl_target`

## Requirements
- R1: While `rst_n` is low, and after it rises, `ack` is 0, `dout` is 0, the captured address and holding word are 0, and every array register reads back as 0.
- R2: When `cap_addr` is the only strobe high and has just risen (low at the previous sampling edge), `din` becomes the current address.
- R3: When `cap_data` alone rises, `din` is stored in the holding word and no array register changes.
- R4: When `wr` alone rises, the holding word is copied into the array register selected by the current address.
- R5: When `rd` alone rises, `dout` takes the addressed register's value at the same edge, so it is valid by the time `ack` is seen high. `dout` changes only on a read and keeps its value otherwise.
- R6: With D = `ack_delay`, the strobe is first sampled high at an edge. `ack` is first seen high after the D-th consecutive edge that samples that strobe alone high.
- R7: `ack` stays high while the acknowledged strobe stays the only strobe high. It is low after the first edge that samples any other strobe pattern.
- R8: While two or more strobes are high together, no action is taken and `ack` stays low. A strobe that remains high after its partner drops is not treated as a new request.
- R9: When the current address is not below the array size (8 by default), a read returns 0 and a write changes no register, including the register that shares its low bits.
- R10: An `ack_delay` of 0 behaves as a delay of 1.
- R11: If the active strobe is released, or another strobe joins it, before the delay has elapsed, `ack` is never raised for that request. The action itself has already taken effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_delay | input | DLY_W (8) | Cycles from strobe to acknowledge, 0 treated as 1 |
| din | input | DW (16) | Address or data word from the master |
| cap_addr | input | 1 | Strobe: capture `din` as address |
| cap_data | input | 1 | Strobe: capture `din` as holding data |
| rd | input | 1 | Strobe: read addressed register to `dout` |
| wr | input | 1 | Strobe: commit holding data to addressed register |
| ack | output | 1 | Acknowledge level |
| dout | output | DW (16) | Read data |

## Verification
The assertions assume that the master obeys the handshake. It drives at most one strobe at a time unless it is deliberately probing the conflict rule. It holds `din` stable around each strobe edge, and it returns all strobes to low before starting the next request. The stimulus changes inputs only at falling clock edges. It always releases a strobe and waits for `ack` to fall before the next request. Overlapping strobes and early releases are confined to dedicated phases. During those phases the reference model predicts a silent `ack`, and it checks the state afterwards through ordinary reads.

// File: rtl/phy_ctl_target.sv
module phy_ctl_target #(
  parameter int DW    = 16,
  parameter int NREGS = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] ack_delay,
  input  logic [DW-1:0]    din,
  input  logic             cap_addr,
  input  logic             cap_data,
  input  logic             rd,
  input  logic             wr,
  output logic             ack,
  output logic [DW-1:0]    dout
);
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [DW-1:0] LIMIT = DW'(NREGS);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK} st_t;

  st_t              state;
  logic [3:0]       stb, stb_q, held;
  logic [DLY_W-1:0] cnt, dly_eff;
  logic [DW-1:0]    cur_addr, hold_q, rd_val;
  logic [DW-1:0]    regs [NREGS];
  logic             start, keep, in_range;
  logic [AW-1:0]    idx;

  assign stb      = {wr, rd, cap_data, cap_addr};
  assign start    = (state == ST_IDLE) && $onehot(stb) && ((stb & ~stb_q) == stb);
  assign keep     = (stb == held);
  assign dly_eff  = (ack_delay == '0) ? DLY_W'(1) : ack_delay;
  assign in_range = cur_addr < LIMIT;
  assign idx      = cur_addr[AW-1:0];
  assign rd_val   = in_range ? regs[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stb_q    <= '0;
      held     <= '0;
      cnt      <= '0;
      ack      <= 1'b0;
      cur_addr <= '0;
      hold_q   <= '0;
      dout     <= '0;
    end else begin
      stb_q <= stb;
      unique case (state)
        ST_IDLE: if (start) begin
          held <= stb;
          if (cap_addr) cur_addr <= din;
          if (cap_data) hold_q   <= din;
          if (rd)       dout     <= rd_val;
          if (dly_eff == DLY_W'(1)) begin
            ack   <= 1'b1;
            state <= ST_ACK;
          end else begin
            cnt   <= dly_eff - DLY_W'(1);
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (!keep) begin
          state <= ST_IDLE;
        end else if (cnt == DLY_W'(1)) begin
          ack   <= 1'b1;
          state <= ST_ACK;
        end else begin
          cnt <= cnt - DLY_W'(1);
        end
        ST_ACK: if (!keep) begin
          ack   <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (start && wr && in_range) begin
      regs[idx] <= hold_q;
    end
  end
endmodule

// File: rtl/phy_ctl_target_chk.sv
module phy_ctl_target_chk #(
  parameter int DW    = 16,
  parameter int NREGS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_addr,
  input logic          cap_data,
  input logic          rd,
  input logic          wr,
  input logic          ack,
  input logic [DW-1:0] dout,
  input logic [DW-1:0] cur_addr
);
  logic [3:0] s;
  assign s = {wr, rd, cap_data, cap_addr};

  p_ack_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(s != 4'b0));

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && s == 4'b0) |=> !ack);

  p_multi_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(s) > 1) |=> !ack);

  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past($onehot(s)));

  p_dout_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(rd));

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rd && (cur_addr >= DW'(NREGS))) |-> (dout == '0));
endmodule

bind phy_ctl_target phy_ctl_target_chk #(.DW(DW), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_addr(cap_addr), .cap_data(cap_data),
  .rd(rd), .wr(wr), .ack(ack), .dout(dout), .cur_addr(cur_addr)
);

// File: tb/sim_phy_ctl_target.sv
`timescale 1ns/1ps
module sim_phy_ctl_target;
  localparam int NREGS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ack_delay = 8'd3;
  logic [15:0] din = '0;
  logic        cap_addr = 0, cap_data = 0, rd = 0, wr = 0;
  logic        ack;
  logic [15:0] dout;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phy_ctl_target u0 (
    .clk(clk), .rst_n(rst_n), .ack_delay(ack_delay), .din(din),
    .cap_addr(cap_addr), .cap_data(cap_data), .rd(rd), .wr(wr),
    .ack(ack), .dout(dout)
  );

  // behavioural reference model
  int  m_mem [NREGS];
  int  m_addr, m_hold, m_dout, m_phase, m_left, m_act;
  bit  m_ack;
  bit  m_prev [4];

  always @(posedge clk) begin
    bit cur [4];
    int n, which, d;
    cur[0] = cap_addr; cur[1] = cap_data; cur[2] = rd; cur[3] = wr;
    n = 0; which = -1;
    for (int k = 0; k < 4; k++) if (cur[k]) begin n++; which = k; end
    if (!rst_n) begin
      foreach (m_mem[k]) m_mem[k] = 0;
      m_addr = 0; m_hold = 0; m_dout = 0; m_phase = 0; m_ack = 0; m_act = -1;
    end else begin
      if (m_phase == 0) begin
        if (n == 1 && !m_prev[which]) begin
          if (which == 0) m_addr = din;
          if (which == 1) m_hold = din;
          if (which == 2) m_dout = (m_addr < NREGS) ? m_mem[m_addr] : 0;
          if (which == 3 && m_addr < NREGS) m_mem[m_addr] = m_hold;
          m_act = which;
          d = (ack_delay == 0) ? 1 : ack_delay;
          m_left = d - 1;
          if (m_left == 0) begin m_ack = 1; m_phase = 2; end
          else m_phase = 1;
        end
      end else if (n != 1 || which != m_act) begin
        m_ack = 0; m_phase = 0;
      end else if (m_phase == 1) begin
        m_left--;
        if (m_left == 0) begin m_ack = 1; m_phase = 2; end
      end
    end
    for (int k = 0; k < 4; k++) m_prev[k] = rst_n ? cur[k] : 1'b0;
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (ack !== m_ack) begin
      fails++;
      $display("FAIL R6/R7 ack per-cycle: actual %0b expected %0b at %0t", ack, m_ack, $time);
    end
    checks++;
    if (dout !== 16'(m_dout)) begin
      fails++;
      $display("FAIL R5 dout per-cycle: actual %h expected %h at %0t", dout, 16'(m_dout), $time);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic set_stb(input int which, input logic v);
    case (which)
      0: cap_addr = v;
      1: cap_data = v;
      2: rd = v;
      default: wr = v;
    endcase
  endtask

  int last_edges;
  logic [15:0] dout_at_ack;

  task automatic op(input int which, input logic [15:0] data, input int extra);
    @(negedge clk);
    din = data;
    set_stb(which, 1'b1);
    last_edges = 0;
    do begin
      @(posedge clk); last_edges++; @(negedge clk);
    end while (!ack && last_edges < 2000);
    dout_at_ack = dout;
    repeat (extra) begin
      chk("R7 ack held", int'(ack), 1);
      @(negedge clk);
    end
    set_stb(which, 1'b0);
    @(negedge clk);
    chk("R7 ack released", int'(ack), 0);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [15:0] v);
    op(0, a, 0); op(1, v, 0); op(3, 16'h0, 0);
  endtask

  task automatic rd_reg(input logic [15:0] a);
    op(0, a, 0); op(2, 16'h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", int'(ack), 0);
    chk("R1 dout in reset", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", int'(ack), 0);
    op(2, 16'h0, 0);
    chk("R1 read of captured address 0 after reset", int'(dout_at_ack), 0);

    op(0, 16'd2, 0);
    op(1, 16'hBEEF, 0);
    rd_reg(16'd2);
    chk("R3 capture data leaves array unchanged", int'(dout_at_ack), 0);
    op(0, 16'd2, 0);
    op(3, 16'h0, 0);
    op(2, 16'h0, 0);
    chk("R4 write commits holding word", int'(dout_at_ack), 16'hBEEF);
    chk("R5 dout valid when ack seen", int'(dout_at_ack), 16'hBEEF);

    for (int i = 0; i < NREGS; i++) wr_reg(16'(i), 16'(16'h1100 + i * 7));
    for (int i = NREGS - 1; i >= 0; i--) begin
      rd_reg(16'(i));
      chk("R2 address selects register", int'(dout_at_ack), 16'h1100 + i * 7);
    end

    foreach (ack_delay_list[j]) begin
      ack_delay = 8'(ack_delay_list[j]);
      op(0, 16'd5, 0);
      chk("R6 strobe-to-ack edges", last_edges, ack_delay_list[j]);
    end
    ack_delay = 8'd0;
    op(1, 16'h0042, 0);
    chk("R10 zero delay acts as one", last_edges, 1);

    ack_delay = 8'd2;
    op(2, 16'h0, 4);
    chk("R7 dout steady over held read", int'(dout), 16'h1100 + 5 * 7);

    @(negedge clk);
    din = 16'd6; cap_addr = 1; cap_data = 1;
    repeat (8) begin @(negedge clk); chk("R8 no ack with two strobes", int'(ack), 0); end
    cap_data = 0;
    repeat (6) begin @(negedge clk); chk("R8 leftover strobe not a request", int'(ack), 0); end
    cap_addr = 0;
    @(negedge clk);
    op(2, 16'h0, 0);
    chk("R8 address unchanged after conflict", int'(dout_at_ack), 16'h1100 + 5 * 7);

    wr_reg(16'd100, 16'h1234);
    rd_reg(16'd100);
    chk("R9 out-of-range read is zero", int'(dout_at_ack), 0);
    rd_reg(16'd4);
    chk("R9 aliased register untouched", int'(dout_at_ack), 16'h1100 + 4 * 7);

    ack_delay = 8'd10;
    op(0, 16'd3, 0);
    @(negedge clk);
    rd = 1;
    repeat (4) begin @(negedge clk); chk("R11 no ack before delay", int'(ack), 0); end
    rd = 0;
    repeat (12) begin @(negedge clk); chk("R11 aborted request stays silent", int'(ack), 0); end
    chk("R11 read took effect", int'(dout), 16'h1100 + 3 * 7);
    @(negedge clk);
    cap_data = 1; din = 16'h7777;
    repeat (3) @(negedge clk);
    wr = 1;
    repeat (12) begin @(negedge clk); chk("R11 joined strobe cancels ack", int'(ack), 0); end
    wr = 0; cap_data = 0;
    ack_delay = 8'd1;
    repeat (2) @(negedge clk);
    op(3, 16'h0, 0);
    op(2, 16'h0, 0);
    chk("R11 cancelled capture still stored", int'(dout_at_ack), 16'h7777);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout cleared by reset", int'(dout), 0);
    op(2, 16'h0, 0);
    chk("R1 address and array cleared", int'(dout_at_ack), 0);
    rd_reg(16'd3);
    chk("R1 register 3 cleared", int'(dout_at_ack), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int ack_delay_list [3] = '{1, 3, 5};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule